// File: doc/BRIEF.md
# Translation Context Register Bank with Fault Capture

This block is the software-visible register file of an I/O address translation unit that serves several independent translation contexts. Each context owns a control word (translation on, TLB invalidate, interrupt on), a translation-table control word, a bus control word, a 64-bit table base split into low and high halves, a memory attribute word, a fault status word and a captured fault address. One 32-bit register port reaches every context through an address decoder. Contexts 0 to 7 occupy consecutive 0x40-byte slots from offset 0. Contexts 8 and up occupy the same slot size in a second window that starts at 0x800.

The table walker and TLB arrays sit outside the block. They appear here as two inputs. A per-context flush-done strobe ends a pending invalidation. A fault event, which carries a context number, a fault kind and an address, records a fault. The block raises a per-context interrupt and one combined interrupt line. Software polls the invalidate bit to see when a flush has finished. It reads the fault address before it clears status, because clearing status hides the address. Status is cleared by writing zero.

Top module: `mmu_ctx_bank`

## Requirements
- R1: After reset every context reads zero in every register, and both `irq` and `ctxIrq` are low.
- R2: Context c (c < 8) starts at byte offset c*0x40. Context c (c >= 8) starts at 0x800+(c-8)*0x40. Addresses outside every context slot, or outside the configured context count, read zero, and writes to them change nothing.
- R3: In the control word (slot offset 0x00), bit 0 is translation enable and bit 2 is interrupt enable. Both read back what was last written.
- R4: Writing 1 to control bit 1 (invalidate) makes that bit read 1. It stays 1 until `flushDone` for that context is high at a clock edge, and reads 0 from the following cycle.
- R5: If an invalidate is pending while translation enable is 0, bit 1 returns to 0 at the next clock edge.
- R6: A fault event sets one status bit (slot offset 0x20) in the named context only when that context's translation enable is 1. Kind 0 sets bit 0 (translation fault), kind 1 sets bit 1 (page fault), kind 2 sets bit 2 (walk abort) and kind 3 sets bit 4 (multiple hit).
- R7: A fault that finds status all zero captures its address: the low 32 bits read at slot offset 0x30 and the upper bits, zero-extended, at 0x34. A later fault that finds status nonzero adds its bit and keeps the first address.
- R8: Writing zero to the status word clears all flags. Any nonzero write to it has no effect. While status is zero, both address words read zero.
- R9: `ctxIrq[c]` is high exactly while context c has interrupt enable 1 and a nonzero status. `irq` is the OR of all `ctxIrq` bits.
- R10: The table control word (0x08, where bit 31 selects the long-descriptor format and bits 7:6 are the start level), the bus word (0x0C), table base low (0x10), table base high (0x14) and the attribute word (0x28) store and return full 32-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| flushDone | input | NCTX | Per-context invalidation completion strobe |
| faultValid | input | 1 | Fault event valid |
| faultCtx | input | CTX_W | Context that took the fault |
| faultKind | input | 2 | Fault kind: 0 translation, 1 page, 2 walk abort, 3 multiple hit |
| faultAddr | input | FAULT_W | Faulting input address |
| ctxIrq | output | NCTX | Per-context interrupt level |
| irq | output | 1 | Combined interrupt level |

## Verification
A decoder fault sends accesses to the wrong slot. It shows on the very next read of a context that was never written, or of a second-window address that should alias nothing. A stuck invalidate state shows as a control read that stays 1 after the done strobe or after translation is turned off, one cycle after the event. A wrong status or capture state shows on the same cycle as an interrupt level that disagrees with enable and status. It also shows on the next address read as a value other than the first fault, or as a nonzero value after a clear.

// File: rtl/mmu_ctx_pkg.sv
package mmu_ctx_pkg;

  localparam int CTX_IDX_W = 4;  // up to 16 contexts

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTL,
    SEL_TCR,
    SEL_BUS,
    SEL_TBL,
    SEL_TBH,
    SEL_STS,
    SEL_MAIR,
    SEL_EAL,
    SEL_EAH
  } regSel_e;

  // register access strobes from decode to storage
  typedef struct packed {
    logic                 hit;
    logic                 wr;
    logic [CTX_IDX_W-1:0] ctx;
    regSel_e              sel;
  } acc_t;

  // fault event strobes from decode to storage
  typedef struct packed {
    logic                 valid;
    logic [CTX_IDX_W-1:0] ctx;
    logic [4:0]           bits;
  } faultStb_t;

endpackage

// File: rtl/mmu_ctx_decode.sv
module mmu_ctx_decode
  import mmu_ctx_pkg::*;
#(
  parameter int NCTX   = 16,
  parameter int ADDR_W = 12,
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              faultValid,
  input  logic [CTX_W-1:0]  faultCtx,
  input  logic [1:0]        faultKind,
  output acc_t              acc,
  output faultStb_t         faultStb
);

  localparam logic [ADDR_W-1:0] WIN2_BASE = ADDR_W'(12'h800);
  localparam int SLOT_W = ADDR_W - 6;

  logic              inHigh;
  logic [ADDR_W-1:0] winOff;
  logic [SLOT_W-1:0] slot;
  logic [3:0]        ctxNum;
  logic              slotOk;

  always_comb begin
    inHigh = regAddr >= WIN2_BASE;
    winOff = inHigh ? (regAddr - WIN2_BASE) : regAddr;
    slot   = winOff[ADDR_W-1:6];
    ctxNum = {inHigh, slot[2:0]};
    slotOk = (slot < SLOT_W'(8)) && (int'(ctxNum) < NCTX);

    acc.ctx = ctxNum;
    unique case (winOff[5:0])
      6'h00:   acc.sel = SEL_CTL;
      6'h08:   acc.sel = SEL_TCR;
      6'h0C:   acc.sel = SEL_BUS;
      6'h10:   acc.sel = SEL_TBL;
      6'h14:   acc.sel = SEL_TBH;
      6'h20:   acc.sel = SEL_STS;
      6'h28:   acc.sel = SEL_MAIR;
      6'h30:   acc.sel = SEL_EAL;
      6'h34:   acc.sel = SEL_EAH;
      default: acc.sel = SEL_NONE;
    endcase
    acc.hit = slotOk && (acc.sel != SEL_NONE);
    acc.wr  = acc.hit && regWe;
  end

  always_comb begin
    faultStb.valid = faultValid;
    faultStb.ctx   = CTX_IDX_W'(faultCtx);
    unique case (faultKind)
      2'd0:    faultStb.bits = 5'b00001;
      2'd1:    faultStb.bits = 5'b00010;
      2'd2:    faultStb.bits = 5'b00100;
      default: faultStb.bits = 5'b10000;
    endcase
  end

endmodule

// File: rtl/mmu_ctx_regs.sv
module mmu_ctx_regs
  import mmu_ctx_pkg::*;
#(
  parameter int NCTX    = 16,
  parameter int FAULT_W = 40
) (
  input  logic               clk,
  input  logic               rstN,
  input  acc_t               acc,
  input  faultStb_t          faultStb,
  input  logic [31:0]        regWdata,
  input  logic [FAULT_W-1:0] faultAddr,
  input  logic [NCTX-1:0]    flushDone,
  output logic [31:0]        regRdata,
  output logic [NCTX-1:0]    ctxEn,
  output logic [NCTX-1:0]    ctxBusy,
  output logic [NCTX-1:0]    stsAny,
  output logic [NCTX-1:0]    ctxIrq
);

  logic [31:0] rdWord [NCTX];

  for (genvar g = 0; g < NCTX; g++) begin : gCtx
    logic               en, busy, intEn;
    logic [31:0]        tcr, busR, tbl, tbh, mair;
    logic [4:0]         sts, stsBase;
    logic [FAULT_W-1:0] ea;
    logic               wrMe, fHit, stsClr;
    logic [31:0]        eaLo, eaHi;

    assign wrMe   = acc.wr && (acc.ctx == CTX_IDX_W'(g));
    assign fHit   = faultStb.valid && (faultStb.ctx == CTX_IDX_W'(g)) && en;
    assign stsClr = wrMe && (acc.sel == SEL_STS) && (regWdata == 32'd0);
    assign stsBase = stsClr ? 5'd0 : sts;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        en    <= 1'b0;
        busy  <= 1'b0;
        intEn <= 1'b0;
        tcr   <= '0;
        busR  <= '0;
        tbl   <= '0;
        tbh   <= '0;
        mair  <= '0;
        sts   <= '0;
        ea    <= '0;
      end else begin
        if (wrMe && acc.sel == SEL_CTL) begin
          en    <= regWdata[0];
          intEn <= regWdata[2];
        end
        if (wrMe && acc.sel == SEL_CTL && regWdata[1])
          busy <= 1'b1;
        else if (flushDone[g] || !en)
          busy <= 1'b0;
        if (wrMe && acc.sel == SEL_TCR)  tcr  <= regWdata;
        if (wrMe && acc.sel == SEL_BUS)  busR <= regWdata;
        if (wrMe && acc.sel == SEL_TBL)  tbl  <= regWdata;
        if (wrMe && acc.sel == SEL_TBH)  tbh  <= regWdata;
        if (wrMe && acc.sel == SEL_MAIR) mair <= regWdata;
        if (fHit) begin
          sts <= stsBase | faultStb.bits;
          if (stsBase == 5'd0) ea <= faultAddr;
        end else begin
          sts <= stsBase;
        end
      end
    end

    assign eaLo = (sts != 5'd0) ? ea[31:0] : 32'd0;
    assign eaHi = (sts != 5'd0) ? 32'(ea >> 32) : 32'd0;

    always_comb begin
      unique case (acc.sel)
        SEL_CTL:  rdWord[g] = {29'd0, intEn, busy, en};
        SEL_TCR:  rdWord[g] = tcr;
        SEL_BUS:  rdWord[g] = busR;
        SEL_TBL:  rdWord[g] = tbl;
        SEL_TBH:  rdWord[g] = tbh;
        SEL_STS:  rdWord[g] = {27'd0, sts};
        SEL_MAIR: rdWord[g] = mair;
        SEL_EAL:  rdWord[g] = eaLo;
        SEL_EAH:  rdWord[g] = eaHi;
        default:  rdWord[g] = 32'd0;
      endcase
    end

    assign ctxEn[g]   = en;
    assign ctxBusy[g] = busy;
    assign stsAny[g]  = |sts;
    assign ctxIrq[g]  = intEn && (|sts);
  end

  assign regRdata = acc.hit ? rdWord[acc.ctx] : 32'd0;

endmodule

// File: rtl/mmu_ctx_bank.sv
module mmu_ctx_bank
  import mmu_ctx_pkg::*;
#(
  parameter int NCTX    = 16,
  parameter int ADDR_W  = 12,
  parameter int FAULT_W = 40,
  localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic [NCTX-1:0]    flushDone,
  input  logic               faultValid,
  input  logic [CTX_W-1:0]   faultCtx,
  input  logic [1:0]         faultKind,
  input  logic [FAULT_W-1:0] faultAddr,
  output logic [NCTX-1:0]    ctxIrq,
  output logic               irq
);

  acc_t            acc;
  faultStb_t       faultStb;
  logic [NCTX-1:0] ctxEn, ctxBusy, stsAny;

  mmu_ctx_decode #(.NCTX(NCTX), .ADDR_W(ADDR_W)) u_decode (
    .regWe      (regWe),
    .regAddr    (regAddr),
    .faultValid (faultValid),
    .faultCtx   (faultCtx),
    .faultKind  (faultKind),
    .acc        (acc),
    .faultStb   (faultStb)
  );

  mmu_ctx_regs #(.NCTX(NCTX), .FAULT_W(FAULT_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .acc       (acc),
    .faultStb  (faultStb),
    .regWdata  (regWdata),
    .faultAddr (faultAddr),
    .flushDone (flushDone),
    .regRdata  (regRdata),
    .ctxEn     (ctxEn),
    .ctxBusy   (ctxBusy),
    .stsAny    (stsAny),
    .ctxIrq    (ctxIrq)
  );

  assign irq = |ctxIrq;

endmodule

// File: rtl/mmu_ctx_bank_chk.sv
module mmu_ctx_bank_chk #(
  parameter int NCTX   = 16,
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic             faultValid,
  input logic [CTX_W-1:0] faultCtx,
  input logic [NCTX-1:0]  flushDone,
  input logic [NCTX-1:0]  ctxEn,
  input logic [NCTX-1:0]  ctxBusy,
  input logic [NCTX-1:0]  stsAny,
  input logic [NCTX-1:0]  ctxIrq,
  input logic             irq
);

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|stsAny)); // R9

  for (genvar i = 0; i < NCTX; i++) begin : gChk
    AST_CTX_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
      ctxIrq[i] |-> stsAny[i]); // R9

    AST_FLUSH_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
      (ctxBusy[i] && flushDone[i] && !regWe) |=> !ctxBusy[i]); // R4

    AST_FLUSH_ENDS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
      (ctxBusy[i] && !ctxEn[i] && !regWe) |=> !ctxBusy[i]); // R5

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (stsAny[i] && !regWe) |=> stsAny[i]); // R8

    AST_STATUS_FROM_ENABLED_FAULT: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stsAny[i]) |-> ($past(faultValid) && ($past(faultCtx) == CTX_W'(i))
                            && $past(ctxEn[i]))); // R6
  end

endmodule

bind mmu_ctx_bank mmu_ctx_bank_chk #(.NCTX(NCTX)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWe      (regWe),
  .faultValid (faultValid),
  .faultCtx   (faultCtx),
  .flushDone  (flushDone),
  .ctxEn      (ctxEn),
  .ctxBusy    (ctxBusy),
  .stsAny     (stsAny),
  .ctxIrq     (ctxIrq),
  .irq        (irq)
);

// File: tb/test_mmu_ctx_bank.sv
module test_mmu_ctx_bank;

  localparam int NCTX    = 16;
  localparam int ADDR_W  = 12;
  localparam int FAULT_W = 40;
  localparam int CTX_W   = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               regWe = 1'b0;
  logic [ADDR_W-1:0]  regAddr = '0;
  logic [31:0]        regWdata = '0;
  logic [31:0]        regRdata;
  logic [NCTX-1:0]    flushDone = '0;
  logic               faultValid = 1'b0;
  logic [CTX_W-1:0]   faultCtx = '0;
  logic [1:0]         faultKind = '0;
  logic [FAULT_W-1:0] faultAddr = '0;
  logic [NCTX-1:0]    ctxIrq;
  logic               irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mmu_ctx_bank #(.NCTX(NCTX), .ADDR_W(ADDR_W), .FAULT_W(FAULT_W)) i_mmu_ctx_bank (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .flushDone(flushDone), .faultValid(faultValid),
    .faultCtx(faultCtx), .faultKind(faultKind), .faultAddr(faultAddr),
    .ctxIrq(ctxIrq), .irq(irq)
  );

  function automatic logic [ADDR_W-1:0] slotBase(input int c);
    return (c < 8) ? ADDR_W'(c * 'h40) : ADDR_W'('h800 + (c - 8) * 'h40);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(req, 64'(regRdata), 64'(exp));
  endtask

  task automatic fault(input int c, input logic [1:0] k, input logic [FAULT_W-1:0] a);
    @(negedge clk);
    faultValid = 1'b1; faultCtx = CTX_W'(c); faultKind = k; faultAddr = a;
    @(negedge clk);
    faultValid = 1'b0;
  endtask

  task automatic t_reset;
    rdCheck("R1 ctl ctx0", slotBase(0), 32'h0);
    rdCheck("R1 tcr ctx9", slotBase(9) + 12'h08, 32'h0);
    rdCheck("R1 sts ctx15", slotBase(15) + 12'h20, 32'h0);
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 ctxIrq", 64'(ctxIrq), 64'd0);
  endtask

  task automatic t_map;
    wr(slotBase(8) + 12'h08, 32'h8000_0080);
    rdCheck("R10 tcr ctx8 at 0x808", 12'h808, 32'h8000_0080);
    wr(12'h208, 32'h0000_FFFF);
    rdCheck("R2 unmapped 0x208 reads 0", 12'h208, 32'h0);
    rdCheck("R2 ctx8 untouched by 0x208", 12'h808, 32'h8000_0080);
    rdCheck("R2 ctx0 tcr untouched", 12'h008, 32'h0);
    wr(slotBase(15) + 12'h10, 32'hDEAD_BEEF);
    rdCheck("R2 ctx15 tbl at 0x9D0", 12'h9D0, 32'hDEAD_BEEF);
    rdCheck("R2 beyond last ctx 0xA10", 12'hA10, 32'h0);
    wr(slotBase(1) + 12'h28, 32'h1234_5678);
    rdCheck("R10 mair ctx1", slotBase(1) + 12'h28, 32'h1234_5678);
    wr(slotBase(5) + 12'h0C, 32'hA5A5_0003);
    rdCheck("R10 bus ctx5", slotBase(5) + 12'h0C, 32'hA5A5_0003);
    wr(slotBase(12) + 12'h14, 32'h0000_00FE);
    rdCheck("R10 tbh ctx12", slotBase(12) + 12'h14, 32'h0000_00FE);
    rdCheck("R2 ctx4 tbh untouched", slotBase(4) + 12'h14, 32'h0);
  endtask

  task automatic t_ctl;
    wr(slotBase(4), 32'h0000_0005);
    rdCheck("R3 en+intEn ctx4", slotBase(4), 32'h5);
    wr(slotBase(4), 32'h0000_0001);
    rdCheck("R3 en only ctx4", slotBase(4), 32'h1);
  endtask

  task automatic t_flush;
    wr(slotBase(9), 32'h0000_0003);
    rdCheck("R4 flush pending", slotBase(9), 32'h3);
    repeat (3) @(negedge clk);
    rdCheck("R4 flush still pending", slotBase(9), 32'h3);
    flushDone[9] = 1'b1;
    @(negedge clk);
    flushDone[9] = 1'b0;
    rdCheck("R4 flush done", slotBase(9), 32'h1);
  endtask

  task automatic t_flushOff;
    wr(slotBase(2), 32'h0000_0002);
    rdCheck("R5 flush set while off", slotBase(2), 32'h2);
    @(negedge clk);
    rdCheck("R5 flush ends next cycle", slotBase(2), 32'h0);
  endtask

  task automatic t_fault;
    fault(0, 2'd0, 40'h11_2222_3333);
    rdCheck("R6 disabled ctx ignores fault", slotBase(0) + 12'h20, 32'h0);
    wr(slotBase(3), 32'h0000_0005);
    fault(3, 2'd3, 40'hAB_1234_5678);
    rdCheck("R6 multi-hit sets bit4", slotBase(3) + 12'h20, 32'h10);
    rdCheck("R7 addr low", slotBase(3) + 12'h30, 32'h1234_5678);
    rdCheck("R7 addr high", slotBase(3) + 12'h34, 32'h0000_00AB);
    check("R9 irq ctx3", 64'(ctxIrq), 64'h0008);
    check("R9 irq line", 64'(irq), 64'd1);
    fault(3, 2'd1, 40'h01_0000_0001);
    rdCheck("R6 page fault adds bit1", slotBase(3) + 12'h20, 32'h12);
    rdCheck("R7 first addr kept", slotBase(3) + 12'h30, 32'h1234_5678);
    wr(slotBase(3) + 12'h20, 32'h0000_0012);
    rdCheck("R8 nonzero write ignored", slotBase(3) + 12'h20, 32'h12);
    wr(slotBase(3) + 12'h20, 32'h0);
    rdCheck("R8 zero write clears", slotBase(3) + 12'h20, 32'h0);
    rdCheck("R8 addr low hidden", slotBase(3) + 12'h30, 32'h0);
    rdCheck("R8 addr high hidden", slotBase(3) + 12'h34, 32'h0);
    check("R9 irq drops", 64'(irq), 64'd0);
    wr(slotBase(10), 32'h0000_0001);
    fault(10, 2'd2, 40'h00_0000_4000);
    rdCheck("R6 walk abort sets bit2", slotBase(10) + 12'h20, 32'h4);
    check("R9 no irq without intEn", 64'(irq), 64'd0);
    fault(10, 2'd0, 40'h00_0000_5000);
    rdCheck("R6 translation fault adds bit0", slotBase(10) + 12'h20, 32'h5);
    rdCheck("R7 ctx10 addr kept", slotBase(10) + 12'h30, 32'h0000_4000);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_ctl();
    t_flush();
    t_flushOff();
    t_fault();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule